// File: doc/BRIEF.md
# SPI Burst-Write Memory Loader

This block is an SPI slave (mode 0: data sampled on the rising clock edge, bits most significant first) that fills a 64-bit-wide on-chip memory, such as a program or coefficient RAM, from an external host. The host lowers the select line and sends a one-byte opcode. For a burst write, four address bytes follow, and then the payload. The block packs each 8-byte payload group into one 64-bit word and issues one write for it. The write address starts at the received address and climbs by 8 bytes per word.

Inside a group the byte order is reversed with respect to memory order. The first byte received lands in the top byte lane of the word and the eighth lands in the bottom lane. After the payload the host repeats the opcode once as a trailer, and the block accepts it without writing it. A frame holds a bounded number of payload bytes, so long images are split into several frames, each with its own start address. The SPI pins are brought into the system clock domain through a short synchroniser and edge detection, so SCLK must run well below the system clock.

Top module: `spi_burst_loader`

## Requirements
- R1: The first byte after select falls (spi_cs_n low) is the opcode. Only 0x05 starts a burst write. Any other opcode causes every later byte of the frame to be ignored, and no write is issued until select rises.
- R2: Bytes 2 to 5 of a burst frame form the 32-bit start address, with the most significant byte sent first. Each byte is received MSB first.
- R3: In each payload group, the k-th byte received (k = 0..7) is placed in mem_wdata bits [63-8k : 56-8k]. The first byte goes to bits 63:56 and the eighth to bits 7:0.
- R4: Each complete 8-byte group produces exactly one write. The i-th write of a frame uses mem_addr = start address + 8*i.
- R5: A single byte left after the last complete group is taken as the trailer. It causes no write and no error.
- R6: After MAX_PAYLOAD payload bytes the next byte is the trailer. Any later bytes in the same frame cause no write.
- R7: If select rises while 2 to 7 bytes of a group are held, that group is dropped and frame_err is set. frame_err stays set until rst_n is asserted.
- R8: Raising select always returns the decoder to the opcode state. A frame cut off in the header leaves no trace on the next frame.
- R9: mem_we is a one-cycle pulse per word. After reset, mem_we and frame_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_mosi | input | 1 | SPI data from the host |
| spi_cs_n | input | 1 | SPI select, active low |
| mem_we | output | 1 | Memory write strobe, one cycle |
| mem_addr | output | 32 | Byte address of the written word |
| mem_wdata | output | 64 | Word to write |
| frame_err | output | 1 | Sticky flag for a truncated group |

## Verification
The bench builds the loader with MAX_PAYLOAD set to 48 instead of 240. This puts the per-frame payload cap and the bytes after it within reach in frames of about sixty bytes. The data width and the two-stage synchroniser keep their defaults. With that setting, random frame lengths cover the full range from one group up to the cap, and a few directed frames cover a truncated header, a partial group and a wrong opcode. The sticky error flag is then shown to survive a clean frame and to clear only on reset.

// File: rtl/spi_burst_loader.sv
module spi_burst_loader #(
  parameter int          ADDR_W      = 32,
  parameter int          DATA_BYTES  = 8,
  parameter int          MAX_PAYLOAD = 240,
  parameter logic [7:0]  CMD_BURST   = 8'h05,
  parameter int          SYNC        = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    spi_sclk,
  input  logic                    spi_mosi,
  input  logic                    spi_cs_n,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [8*DATA_BYTES-1:0] mem_wdata,
  output logic                    frame_err
);
  localparam int DATA_W     = 8 * DATA_BYTES;
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int HDR_W      = $clog2(ADDR_BYTES);
  localparam int GRP_W      = $clog2(DATA_BYTES);
  localparam int PAY_W      = $clog2(MAX_PAYLOAD + 1);

  typedef enum logic [2:0] {S_CMD, S_ADDR, S_DATA, S_TRAIL, S_SKIP} state_t;

  logic [SYNC:0]       sclk_q, mosi_q, cs_q;
  state_t              st;
  logic [2:0]          bit_cnt;
  logic [6:0]          shreg;
  logic [HDR_W-1:0]    hdr_cnt;
  logic [GRP_W-1:0]    grp_cnt;
  logic [PAY_W-1:0]    pay_cnt;
  logic [ADDR_W-1:0]   wr_addr;
  logic [DATA_W-1:0]   data_buf;

  wire sclk_rise = sclk_q[SYNC-1] & ~sclk_q[SYNC];
  wire cs_hi     = cs_q[SYNC-1];
  wire cs_rise   = cs_q[SYNC-1] & ~cs_q[SYNC];
  wire [7:0] rx_byte = {shreg, mosi_q[SYNC-1]};
  wire byte_done = sclk_rise && (bit_cnt == 3'd7);
  wire grp_last  = (grp_cnt == GRP_W'(DATA_BYTES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= '0;
      mosi_q    <= '0;
      cs_q      <= '1;
      st        <= S_CMD;
      bit_cnt   <= '0;
      shreg     <= '0;
      hdr_cnt   <= '0;
      grp_cnt   <= '0;
      pay_cnt   <= '0;
      wr_addr   <= '0;
      data_buf  <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      frame_err <= 1'b0;
    end else begin
      sclk_q <= {sclk_q[SYNC-1:0], spi_sclk};
      mosi_q <= {mosi_q[SYNC-1:0], spi_mosi};
      cs_q   <= {cs_q[SYNC-1:0], spi_cs_n};
      mem_we <= 1'b0;
      if (cs_rise && st == S_DATA && grp_cnt > GRP_W'(1))
        frame_err <= 1'b1;
      if (cs_hi) begin
        st      <= S_CMD;
        bit_cnt <= '0;
        hdr_cnt <= '0;
        grp_cnt <= '0;
        pay_cnt <= '0;
      end else if (sclk_rise) begin
        bit_cnt <= bit_cnt + 3'd1;
        shreg   <= rx_byte[6:0];
        if (byte_done) begin
          case (st)
            S_CMD:  st <= (rx_byte == CMD_BURST) ? S_ADDR : S_SKIP;
            S_ADDR: begin
              wr_addr <= {wr_addr[ADDR_W-9:0], rx_byte};
              hdr_cnt <= hdr_cnt + HDR_W'(1);
              if (hdr_cnt == HDR_W'(ADDR_BYTES - 1)) st <= S_DATA;
            end
            S_DATA: begin
              pay_cnt <= pay_cnt + PAY_W'(1);
              if (pay_cnt == PAY_W'(MAX_PAYLOAD - 1)) st <= S_TRAIL;
              if (grp_last) begin
                mem_we    <= 1'b1;
                mem_addr  <= wr_addr;
                mem_wdata <= {data_buf[DATA_W-9:0], rx_byte};
                wr_addr   <= wr_addr + ADDR_W'(DATA_BYTES);
                grp_cnt   <= '0;
              end else begin
                data_buf <= {data_buf[DATA_W-9:0], rx_byte};
                grp_cnt  <= grp_cnt + GRP_W'(1);
              end
            end
            S_TRAIL: st <= S_SKIP;
            default: st <= S_SKIP;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/spi_burst_loader_chk.sv
module spi_burst_loader_chk #(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_cs_n,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              frame_err
);
  logic [ADDR_W-1:0] prev_addr;
  logic              have_prev;
  logic [1:0]        cs_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_addr <= '0;
      have_prev <= 1'b0;
      cs_cnt    <= '0;
    end else begin
      cs_cnt <= spi_cs_n ? ((cs_cnt == 2'd3) ? cs_cnt : cs_cnt + 2'd1) : 2'd0;
      if (spi_cs_n) have_prev <= 1'b0;
      else if (mem_we) begin
        have_prev <= 1'b1;
        prev_addr <= mem_addr;
      end
    end
  end

  p_we_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && have_prev) |-> (mem_addr == prev_addr + ADDR_W'(DATA_BYTES)));
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);
  p_err_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> spi_cs_n);
  p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_cnt == 2'd3) |-> !mem_we);
endmodule

bind spi_burst_loader spi_burst_loader_chk #(.ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n),
  .mem_we(mem_we), .mem_addr(mem_addr), .frame_err(frame_err));

// File: tb/spi_burst_loader_bench.sv
`timescale 1ns/1ps
module spi_burst_loader_bench;
  localparam int MAXP = 48;
  localparam int HP   = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1;
  logic        mem_we, frame_err;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata;

  always #2 clk = ~clk;

  spi_burst_loader #(.MAX_PAYLOAD(MAXP)) u_spi_burst_loader (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_mosi(mosi), .spi_cs_n(cs_n),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .frame_err(frame_err));

  int checks = 0, errors = 0, cap_n = 0, cyc = 0;
  logic [31:0] cap_a [0:511];
  logic [63:0] cap_d [0:511];
  logic [7:0]  fb [0:79];
  bit exp_err = 0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (mem_we) begin
      cap_a[cap_n % 512] <= mem_addr;
      cap_d[cap_n % 512] <= mem_wdata;
      cap_n <= cap_n + 1;
    end
    if (cyc == 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      mosi = b[i];
      repeat (HP) @(negedge clk);
      sclk = 1'b1;
      repeat (HP) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  function automatic logic [63:0] exp_word(input int first);
    logic [63:0] w = '0;
    for (int k = 0; k < 8; k++) w = {w[55:0], fb[first + k]};
    return w;
  endfunction

  task automatic run_frame(input int n, input string tag);
    int base, groups, r;
    logic [31:0] a;
    base = cap_n;
    groups = 0;
    if (n >= 5 && fb[0] == 8'h05) begin
      r = n - 5;
      if (r > MAXP) groups = MAXP / 8;
      else begin
        groups = r / 8;
        if (r % 8 >= 2) exp_err = 1;
      end
    end
    a = {fb[1], fb[2], fb[3], fb[4]};
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
    for (int i = 0; i < n; i++) send_byte(fb[i]);
    repeat (HP) @(negedge clk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
    chk(cap_n - base == groups, {tag, " R4 write count"}, 64'(cap_n - base), 64'(groups));
    for (int g = 0; g < groups && g < cap_n - base; g++) begin
      chk(cap_a[(base + g) % 512] == a + 32'(8 * g), {tag, " R2/R4 address"},
          64'(cap_a[(base + g) % 512]), 64'(a + 32'(8 * g)));
      chk(cap_d[(base + g) % 512] == exp_word(5 + 8 * g), {tag, " R3 word order"},
          cap_d[(base + g) % 512], exp_word(5 + 8 * g));
    end
    chk(frame_err == exp_err, {tag, " R7 error flag"}, 64'(frame_err), 64'(exp_err));
  endtask

  task automatic hdr(input logic [7:0] c, input logic [31:0] a);
    fb[0] = c; fb[1] = a[31:24]; fb[2] = a[23:16]; fb[3] = a[15:8]; fb[4] = a[7:0];
  endtask

  task automatic fill(input int from, input int cnt);
    for (int i = 0; i < cnt; i++) fb[from + i] = 8'($urandom);
  endtask

  initial begin
    int g;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    chk(mem_we == 1'b0, "R9 reset we", 64'(mem_we), 64'd0);
    chk(frame_err == 1'b0, "R9 reset err", 64'(frame_err), 64'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    hdr(8'h05, 32'h5000_0000);
    for (int i = 0; i < 16; i++) fb[5 + i] = 8'(i + 1);
    fb[21] = 8'h05;
    run_frame(22, "directed R5 trailer");

    hdr(8'h03, 32'h1000_0000);
    fill(5, 16);
    run_frame(21, "R1 wrong opcode");

    for (int t = 0; t < 6; t++) begin
      g = 1 + int'($urandom % 6);
      hdr(8'h05, {$urandom} & 32'hFFFF_FFF8);
      fill(5, 8 * g);
      fb[5 + 8 * g] = 8'h05;
      run_frame(6 + 8 * g, "random R3/R4");
    end

    hdr(8'h05, 32'h6000_0100);
    fill(5, MAXP + 9);
    run_frame(5 + MAXP + 9, "R6 payload cap");

    hdr(8'h05, 32'h0000_0040);
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
    send_byte(8'h05); send_byte(8'hAA); send_byte(8'hBB);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
    fill(5, 16);
    fb[21] = 8'h05;
    run_frame(22, "R8 header abort");

    hdr(8'h05, 32'h0000_2000);
    fill(5, 11);
    run_frame(16, "R7 partial group");
    chk(frame_err == 1'b1, "R7 set", 64'(frame_err), 64'd1);

    hdr(8'h05, 32'h0000_3000);
    fill(5, 8);
    fb[13] = 8'h05;
    run_frame(14, "R7 sticky R8 restart");

    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(frame_err == 1'b0, "R7 cleared by reset", 64'(frame_err), 64'd0);
    rst_n = 1'b1;
    exp_err = 0;
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule